// File: doc/BRIEF.md
# Channel Bring-Up Sequencer

This block decides when a multi-lane link channel may carry traffic. It starts once every lane reports that it is up. It first has the transmitters send not-aligned idle blocks for a fixed number of block slots. It then has them send ready-marked idle blocks while it waits for the far end. It declares the channel up only when two things have happened: the far end has been seen ready often enough, and enough ready-marked idles have gone out. A single stray ready marker from the partner cannot bring the channel up, because several detections are needed.

All counting is qualified by per-block valid strobes. Transmit counters move only on slots where a block is actually sent. The receive counter moves only on valid decoded idle blocks that carry the ready marker. Every counter saturates, so each done condition holds until the sequencer returns to its reset state. With several lanes, a loss of any lane sends the sequencer back to reset. A single-lane build leaves lane loss to the lane logic and reacts only to the reset input.

Top module: `chan_init_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tx_na_idle`, `tx_rdy_idle` and `channel_up` are all low.
- R2: From the reset state, the sequencer moves to the not-aligned phase on the first clock edge at which all `lane_up` bits are 1; `tx_na_idle` is high in that phase.
- R3: In the not-aligned phase, a 4-bit counter advances on each edge with `tx_blk_valid` high and stops at 15. On the next edge after it reaches 15, the sequencer moves to the wait phase, where `tx_rdy_idle` is high and `tx_na_idle` is low.
- R4: The far end is taken as ready only at the eighth qualifying ready-marker reception, counted outside the reset state. A 3-bit counter holds the first seven receptions and stops at 7.
- R5: A reception qualifies only when `rx_blk_valid`, `rx_idle` and `rx_ready_mark` are all high on the same edge. A marker without the idle flag, or without the valid strobe, is not counted.
- R6: In the wait phase, a 6-bit counter advances on each edge with `tx_blk_valid` high and stops at 63. The sequencer enters the ready phase on the edge after both the counter is at 63 and the far end is ready. With the far end already ready, exactly 63 valid transmit slots in the wait phase are required.
- R7: `channel_up` is high exactly while the sequencer is in the ready phase. It rises on the same edge the ready phase is entered, and at most one of `tx_na_idle`, `tx_rdy_idle`, `channel_up` is high.
- R8: With LANES > 1, any `lane_up` bit low at an edge returns the sequencer to reset at that edge, so `channel_up` falls one edge after the lane drops.
- R9: With LANES = 1, a low `lane_up` does not leave the ready phase; only `rst` does.
- R10: Transmit counters do not advance on edges where `tx_blk_valid` is low, so the not-aligned phase is held indefinitely without valid slots.
- R11: All counts and the far-end-ready flag are cleared in the reset state. A second bring-up needs a fresh 15 not-aligned slots, 63 wait-phase slots and eight markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_up | input | LANES | One lane-ready flag per lane |
| tx_blk_valid | input | 1 | A block is sent in this slot |
| rx_blk_valid | input | 1 | A decoded received block is present this cycle |
| rx_idle | input | 1 | The received block is an idle block |
| rx_ready_mark | input | 1 | The received idle carries the ready marker |
| tx_na_idle | output | 1 | Transmitters send not-aligned idles |
| tx_rdy_idle | output | 1 | Transmitters send ready-marked idles |
| channel_up | output | 1 | Channel is up, registered |

## Verification
The bring-up is driven under several patterns, each chosen to separate one condition from the others. In one, the far end becomes ready long before the transmit count is complete, so the 63-slot rule is the one that gates entry. In another, the transmit count is complete first and the markers arrive afterwards, so the eighth-marker rule gates entry; the seventh marker must not bring the channel up. Markers are also sent without their idle flag or without their valid strobe, and must not count. Lanes are dropped after bring-up to show the difference between the multi-lane and single-lane builds, and a second bring-up shows that no count survives a pass through reset.

// File: rtl/chan_init_seq.sv
`timescale 1ns/1ps
module chan_init_seq #(
  parameter int LANES = 4,
  parameter int NA_W  = 4,
  parameter int TXI_W = 6,
  parameter int RR_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_up,
  input  logic             tx_blk_valid,
  input  logic             rx_blk_valid,
  input  logic             rx_idle,
  input  logic             rx_ready_mark,
  output logic             tx_na_idle,
  output logic             tx_rdy_idle,
  output logic             channel_up
);
  localparam logic [1:0] S_RST = 2'd0, S_NA = 2'd1, S_WAIT = 2'd2, S_UP = 2'd3;

  logic [1:0]       state, state_n;
  logic [NA_W-1:0]  na_cnt;
  logic [TXI_W-1:0] txi_cnt;
  logic [RR_W-1:0]  rr_cnt;
  logic             rem_rdy, up_q;

  wire all_up  = &lane_up;
  wire drop    = (LANES > 1) ? ~all_up : 1'b0;
  wire na_done = &na_cnt;
  wire tx_done = &txi_cnt;
  wire rr_det  = rx_blk_valid & rx_idle & rx_ready_mark;

  always_comb begin
    state_n = state;
    case (state)
      S_RST:   if (all_up) state_n = S_NA;
      S_NA:    if (na_done) state_n = S_WAIT;
      S_WAIT:  if (tx_done && rem_rdy) state_n = S_UP;
      default: state_n = S_UP;
    endcase
    if (drop) state_n = S_RST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_RST;
      up_q  <= 1'b0;
    end else begin
      state <= state_n;
      up_q  <= (state_n == S_UP);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || state == S_RST) begin
      na_cnt  <= '0;
      txi_cnt <= '0;
      rr_cnt  <= '0;
      rem_rdy <= 1'b0;
    end else begin
      if (state == S_NA && tx_blk_valid && !na_done)
        na_cnt <= na_cnt + 1'b1;
      if (state == S_WAIT && tx_blk_valid && !tx_done)
        txi_cnt <= txi_cnt + 1'b1;
      if (rr_det) begin
        if (&rr_cnt) rem_rdy <= 1'b1;
        else         rr_cnt  <= rr_cnt + 1'b1;
      end
    end
  end

  assign tx_na_idle  = (state == S_NA);
  assign tx_rdy_idle = (state == S_WAIT);
  assign channel_up  = up_q;
endmodule

module chan_init_seq_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] lane_up,
  input logic             tx_na_idle,
  input logic             tx_rdy_idle,
  input logic             channel_up,
  input logic             rem_rdy,
  input logic             tx_done
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !channel_up && !tx_na_idle && !tx_rdy_idle);

  // R7
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_na_idle, tx_rdy_idle, channel_up}));

  // R6
  up_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(channel_up) |-> $past(rem_rdy && tx_done && tx_rdy_idle));

  // R3
  wait_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_rdy_idle) |-> $past(tx_na_idle));

  // R8
  lane_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (LANES > 1 && !(&lane_up)) |=> !channel_up && !tx_na_idle && !tx_rdy_idle);
endmodule

bind chan_init_seq chan_init_seq_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .lane_up(lane_up), .tx_na_idle(tx_na_idle),
  .tx_rdy_idle(tx_rdy_idle), .channel_up(channel_up), .rem_rdy(rem_rdy),
  .tx_done(tx_done)
);

// File: tb/test_chan_init_seq.sv
`timescale 1ns/1ps
module test_chan_init_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] lanes = 4'b0000;
  logic txv = 1'b0, rxv = 1'b0, idl = 1'b0, mrk = 1'b0;
  logic na, ri, up, na1, ri1, up1;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chan_init_seq #(.LANES(4)) i_chan_init_seq (
    .clk(clk), .rst(rst), .lane_up(lanes), .tx_blk_valid(txv), .rx_blk_valid(rxv),
    .rx_idle(idl), .rx_ready_mark(mrk), .tx_na_idle(na), .tx_rdy_idle(ri), .channel_up(up));

  chan_init_seq #(.LANES(1)) i_chan_init_seq_1 (
    .clk(clk), .rst(rst), .lane_up(lanes[0]), .tx_blk_valid(txv), .rx_blk_valid(rxv),
    .rx_idle(idl), .rx_ready_mark(mrk), .tx_na_idle(na1), .tx_rdy_idle(ri1), .channel_up(up1));

  // lanes, txv, rxv, idle, mark, edges, exp na, exp ri, exp up, requirement
  localparam int N = 17;
  localparam logic [21:0] VEC [N] = '{
    {4'b1111,1'b1,1'b0,1'b0,1'b0,7'd1 ,1'b1,1'b0,1'b0,4'd2},  // R2
    {4'b1111,1'b1,1'b0,1'b0,1'b0,7'd15,1'b1,1'b0,1'b0,4'd3},  // R3
    {4'b1111,1'b1,1'b0,1'b0,1'b0,7'd1 ,1'b0,1'b1,1'b0,4'd3},  // R3
    {4'b1111,1'b1,1'b1,1'b1,1'b1,7'd7 ,1'b0,1'b1,1'b0,4'd4},  // R4
    {4'b1111,1'b1,1'b0,1'b0,1'b0,7'd56,1'b0,1'b1,1'b0,4'd4},  // R4 seven only
    {4'b1111,1'b0,1'b1,1'b1,1'b0,7'd5 ,1'b0,1'b1,1'b0,4'd5},  // R5 no mark
    {4'b1111,1'b0,1'b0,1'b1,1'b1,7'd3 ,1'b0,1'b1,1'b0,4'd5},  // R5 no valid
    {4'b1111,1'b0,1'b1,1'b0,1'b1,7'd3 ,1'b0,1'b1,1'b0,4'd5},  // R5 no idle
    {4'b1111,1'b0,1'b1,1'b1,1'b1,7'd1 ,1'b0,1'b1,1'b0,4'd4},  // R4 eighth
    {4'b1111,1'b0,1'b0,1'b0,1'b0,7'd1 ,1'b0,1'b0,1'b1,4'd7},  // R7
    {4'b1110,1'b0,1'b0,1'b0,1'b0,7'd1 ,1'b0,1'b0,1'b0,4'd8},  // R8
    {4'b1111,1'b1,1'b1,1'b1,1'b1,7'd1 ,1'b1,1'b0,1'b0,4'd11}, // R11
    {4'b1111,1'b1,1'b1,1'b1,1'b1,7'd15,1'b1,1'b0,1'b0,4'd11}, // R11
    {4'b1111,1'b1,1'b0,1'b0,1'b0,7'd1 ,1'b0,1'b1,1'b0,4'd11}, // R11
    {4'b1111,1'b1,1'b0,1'b0,1'b0,7'd62,1'b0,1'b1,1'b0,4'd6},  // R6 one short
    {4'b1111,1'b1,1'b0,1'b0,1'b0,7'd1 ,1'b0,1'b1,1'b0,4'd6},  // R6 63rd slot
    {4'b1111,1'b0,1'b0,1'b0,1'b0,7'd1 ,1'b0,1'b0,1'b1,4'd6}   // R6
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic outs(input string tag, input logic en, input logic er, input logic eu);
    chk({tag, " tx_na_idle"}, na, en);
    chk({tag, " tx_rdy_idle"}, ri, er);
    chk({tag, " channel_up"}, up, eu);
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    run(3);
    outs("R1 in reset", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    run(1);
    outs("R1 after reset", 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < N; k++) begin
      {lanes, txv, rxv, idl, mrk} = VEC[k][21:14];
      run(int'(VEC[k][13:7]));
      outs($sformatf("R%0d vector %0d", VEC[k][3:0], k), VEC[k][6], VEC[k][5], VEC[k][4]);
    end
    // R10: no valid transmit slots, not-aligned phase holds
    lanes = 4'b0111; txv = 1'b0; run(1);
    lanes = 4'b1111; run(20);
    outs("R10 held", 1'b1, 1'b0, 1'b0);
    // R1: reset from mid-sequence
    rst = 1'b1; run(2);
    outs("R1 mid reset", 1'b0, 1'b0, 1'b0);
    chk("R1 single-lane channel_up", up1, 1'b0);
    rst = 1'b0;
    // R6/R4: full bring-up with markers early
    txv = 1'b1; rxv = 1'b1; idl = 1'b1; mrk = 1'b1;
    run(80);
    outs("R6 edge 80", 1'b0, 1'b1, 1'b0);
    run(1);
    outs("R7 edge 81", 1'b0, 1'b0, 1'b1);
    chk("R9 single-lane up", up1, 1'b1);
    // R8 / R9: all lanes drop
    lanes = 4'b0000; txv = 1'b0; rxv = 1'b0;
    run(1);
    chk("R8 multi-lane channel_up", up, 1'b0);
    chk("R9 single-lane channel_up", up1, 1'b1);
    run(3);
    chk("R9 single-lane held", up1, 1'b1);
    rst = 1'b1; run(1);
    chk("R9 single-lane reset", up1, 1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule